// File: doc/BRIEF.md
# Tree-Structured Iterated Von Neumann Debiaser

This block removes bias from a stream of independent raw bits by cascading small pair-processing elements into a binary tree. Each element groups the bits it receives into consecutive pairs. For every pair it can emit a Von Neumann bit, and it always produces a parity bit. When the two bits of a pair are equal, it also produces a residual bit. The parity bit feeds the element's left child and the residual bit feeds its right child. A stream whose child is absent is dropped. The Von Neumann bits of every element are gathered into one output stream.

The tree shape is fixed at elaboration from a bit-string parameter. The tree need not be complete, so any element count can be traded against throughput. The raw source drives `raw_bit`/`raw_valid` and watches `raw_ready`. The consumer takes debiased bits over a ready/valid pair. Each element is a two-state machine. In `PE_WAIT_FIRST`, an incoming bit is stored and the element moves to `PE_HOLD_FIRST`. In `PE_HOLD_FIRST`, an incoming bit completes the pair, the element emits its outputs combinationally, and it returns to `PE_WAIT_FIRST`. Without input, both states hold.

Top module: `tree_debias`

## Requirements
- R1: `SHAPE` holds the tree description in its low `SHAPE_LEN` bits, first character in the most significant of them. A tree is '1', then its left-subtree string, then '0', then its right-subtree string; the empty tree is the empty string, so "10" is one element. Elements are numbered in the order of their '1' characters, with the root as element 0.
- R2: Each element splits the bits it receives into non-overlapping consecutive pairs, starting with the first bit it receives after reset.
- R3: A pair (a, b) with a different from b emits the Von Neumann bit b, so "01" gives 1 and "10" gives 0. An equal pair emits no Von Neumann bit.
- R4: Every pair sends a XOR b to the element's left child, when that child exists.
- R5: An equal pair sends a to the element's right child, when that child exists. Parity or residual bits with no child are dropped.
- R6: The output sequence equals a model of the same tree. The Von Neumann bits caused by one raw bit are appended in increasing element number.
- R7: A Von Neumann bit is stored at the clock edge that accepts the raw bit completing its pair. It appears on `out_bit`/`out_valid` in the following cycle when the buffer held nothing before.
- R8: `raw_ready` is low while the buffer has fewer free places than there are elements. A raw bit offered while `raw_ready` is low is ignored and does not alter pairing or output.
- R9: While `out_valid` is high and `out_ready` is low, `out_bit` and `out_valid` hold. A bit leaves the buffer only when `out_valid` and `out_ready` are both high.
- R10: Reset clears the buffer and every element's pairing state. After reset, `out_valid` is low and `raw_ready` is high.
- R11: With the single-element shape "10", the output equals classic Von Neumann debiasing of the accepted raw bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_bit | input | 1 | Raw biased bit |
| raw_valid | input | 1 | `raw_bit` is offered this cycle |
| raw_ready | output | 1 | Block accepts a raw bit this cycle |
| out_bit | output | 1 | Debiased bit at the buffer head |
| out_valid | output | 1 | `out_bit` holds a buffered bit |
| out_ready | input | 1 | Consumer takes `out_bit` this cycle |

## Verification
All element outputs are combinational within the cycle a pair completes. A Von Neumann bit is therefore written at the same edge that accepts the completing raw bit, and it becomes visible on the output one cycle after that edge. Both `raw_ready` and `out_valid` depend only on the buffer fill, so each can change only one cycle after an edge. The bench drives each instance just after the falling edge and samples its outputs 1 ns later. A handshake is logged as accepted only when the sampled ready and the driven valid are both high, and the reference models see exactly those accepted bits. The directed latency case checks that nothing is visible after the first bit of a pair, and that the bit is present in the cycle after the second.

// File: rtl/tdb_pkg.sv
package tdb_pkg;

    localparam int SHAPE_MAX = 64;
    localparam int SHAPE_IW  = $clog2(SHAPE_MAX);

    typedef enum logic {
        PE_WAIT_FIRST = 1'b0,
        PE_HOLD_FIRST = 1'b1
    } pe_state_t;

    // character p of the string, counted from the first character
    function automatic logic shape_char(logic [SHAPE_MAX-1:0] s, int len, int p);
        return s[SHAPE_IW'(len - 1 - p)];
    endfunction

    function automatic int count_nodes(logic [SHAPE_MAX-1:0] s, int len);
        int c = 0;
        for (int p = 0; p < len; p++) begin
            if (shape_char(s, len, p)) c++;
        end
        return c;
    endfunction

    // number of '1' characters strictly before position p
    function automatic int nodes_before(logic [SHAPE_MAX-1:0] s, int len, int p);
        int c = 0;
        for (int q = 0; q < p; q++) begin
            if (shape_char(s, len, q)) c++;
        end
        return c;
    endfunction

    function automatic int node_pos(logic [SHAPE_MAX-1:0] s, int len, int k);
        int c   = 0;
        int res = -1;
        for (int p = 0; p < len; p++) begin
            if (shape_char(s, len, p)) begin
                if (c == k) res = p;
                c++;
            end
        end
        return res;
    endfunction

    // position of the '0' that closes the left subtree of the node at p
    function automatic int close_pos(logic [SHAPE_MAX-1:0] s, int len, int p);
        int depth = 0;
        int res   = -1;
        for (int q = p + 1; q < len; q++) begin
            if (res < 0) begin
                if (shape_char(s, len, q)) depth++;
                else if (depth == 0) res = q;
                else depth--;
            end
        end
        return res;
    endfunction

    function automatic int parent_node(logic [SHAPE_MAX-1:0] s, int len, int k);
        int p   = node_pos(s, len, k);
        int res = -1;
        if (p > 0) begin
            if (shape_char(s, len, p - 1)) begin
                res = nodes_before(s, len, p - 1);
            end else begin
                for (int q = 0; q < p - 1; q++) begin
                    if (shape_char(s, len, q) && close_pos(s, len, q) == p - 1)
                        res = nodes_before(s, len, q);
                end
            end
        end
        return res;
    endfunction

    function automatic logic is_left_child(logic [SHAPE_MAX-1:0] s, int len, int k);
        int p = node_pos(s, len, k);
        return (p > 0) && shape_char(s, len, p - 1);
    endfunction

endpackage

// File: rtl/tdb_pair.sv
module tdb_pair
    import tdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_bit,
    output logic pair_valid,
    output logic pair_first,
    output logic pair_second
);

    pe_state_t state_q;
    pe_state_t state_d;
    logic      first_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PE_WAIT_FIRST: if (in_valid) state_d = PE_HOLD_FIRST;
            PE_HOLD_FIRST: if (in_valid) state_d = PE_WAIT_FIRST;
            default:       state_d = PE_WAIT_FIRST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PE_WAIT_FIRST;
            first_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (in_valid && state_q == PE_WAIT_FIRST) first_q <= in_bit;
        end
    end

    always_comb begin
        pair_valid  = in_valid && (state_q == PE_HOLD_FIRST);
        pair_first  = first_q;
        pair_second = in_bit;
    end

endmodule

// File: rtl/tdb_vn_fifo.sv
module tdb_vn_fifo #(
    parameter int NIN = 4,
    parameter int AW  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NIN-1:0] wr_valid,
    input  logic [NIN-1:0] wr_bit,
    output logic          out_valid,
    output logic          out_bit,
    input  logic          out_ready,
    output logic [AW:0]   fill,
    output logic          space_ok
);

    localparam int DEPTH = 1 << AW;
    localparam int FW    = AW + 1;

    logic [DEPTH-1:0] mem_q;
    logic [AW-1:0]    wr_ptr_q;
    logic [AW-1:0]    rd_ptr_q;
    logic [FW-1:0]    fill_q;
    logic [FW-1:0]    ofs [NIN+1];
    logic             pop;

    // running offset of each writer inside this cycle's burst
    assign ofs[0] = '0;
    for (genvar k = 0; k < NIN; k++) begin : g_ofs
        assign ofs[k+1] = ofs[k] + FW'(wr_valid[k]);
    end

    assign out_valid = (fill_q != '0);
    assign out_bit   = mem_q[rd_ptr_q];
    assign pop       = out_valid && out_ready;
    assign fill      = fill_q;
    assign space_ok  = (FW'(DEPTH) - fill_q) >= FW'(NIN);

    always_ff @(posedge clk) begin
        for (int k = 0; k < NIN; k++) begin
            if (wr_valid[k]) mem_q[wr_ptr_q + ofs[k][AW-1:0]] <= wr_bit[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
        end else begin
            wr_ptr_q <= wr_ptr_q + ofs[NIN][AW-1:0];
            rd_ptr_q <= rd_ptr_q + AW'(pop);
            fill_q   <= fill_q + ofs[NIN] - FW'(pop);
        end
    end

endmodule

// File: rtl/tree_debias.sv
module tree_debias
    import tdb_pkg::*;
#(
    parameter int                   SHAPE_LEN = 8,
    parameter logic [SHAPE_MAX-1:0] SHAPE     = 64'b11100100,
    parameter int                   FIFO_AW   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_bit,
    input  logic raw_valid,
    output logic raw_ready,
    output logic out_bit,
    output logic out_valid,
    input  logic out_ready
);

    localparam int N_ELEM = count_nodes(SHAPE, SHAPE_LEN);
    localparam int FILL_W = FIFO_AW + 1;

    logic [N_ELEM-1:0] e_in_valid;
    logic [N_ELEM-1:0] e_in_bit;
    logic [N_ELEM-1:0] pair_v;
    logic [N_ELEM-1:0] pair_a;
    logic [N_ELEM-1:0] pair_b;
    logic [N_ELEM-1:0] vn_valid;
    logic [N_ELEM-1:0] vn_bit;
    logic [FILL_W-1:0] fifo_fill;
    logic              space_ok;

    assign raw_ready = space_ok;

    for (genvar k = 0; k < N_ELEM; k++) begin : g_node
        localparam int   PARENT  = parent_node(SHAPE, SHAPE_LEN, k);
        localparam logic ON_LEFT = is_left_child(SHAPE, SHAPE_LEN, k);

        if (k == 0) begin : g_root
            assign e_in_valid[k] = raw_valid && space_ok;
            assign e_in_bit[k]   = raw_bit;
        end else if (ON_LEFT) begin : g_left
            // parity stream of the parent
            assign e_in_valid[k] = pair_v[PARENT];
            assign e_in_bit[k]   = pair_a[PARENT] ^ pair_b[PARENT];
        end else begin : g_right
            // residual stream of the parent
            assign e_in_valid[k] = pair_v[PARENT] && (pair_a[PARENT] == pair_b[PARENT]);
            assign e_in_bit[k]   = pair_a[PARENT];
        end

        tdb_pair u_pair (
            .clk         (clk),
            .rst_n       (rst_n),
            .in_valid    (e_in_valid[k]),
            .in_bit      (e_in_bit[k]),
            .pair_valid  (pair_v[k]),
            .pair_first  (pair_a[k]),
            .pair_second (pair_b[k])
        );

        assign vn_valid[k] = pair_v[k] && (pair_a[k] != pair_b[k]);
        assign vn_bit[k]   = pair_b[k];
    end

    tdb_vn_fifo #(
        .NIN (N_ELEM),
        .AW  (FIFO_AW)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (vn_valid),
        .wr_bit    (vn_bit),
        .out_valid (out_valid),
        .out_bit   (out_bit),
        .out_ready (out_ready),
        .fill      (fifo_fill),
        .space_ok  (space_ok)
    );

endmodule

// File: rtl/tree_debias_chk.sv
module tree_debias_chk #(
    parameter int NELEM = 4,
    parameter int FAW   = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         raw_valid,
    input logic         raw_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic         out_bit,
    input logic [FAW:0] fill
);

    localparam int DEPTH = 1 << FAW;

    AST_RESET_EMPTY: assert property (@(posedge clk)
        !rst_n |=> !out_valid && raw_ready);  // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_bit));  // R9

    AST_STALL_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> int'(fill) >= int'($past(fill)));  // R9

    AST_IDLE_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(raw_valid && raw_ready) |=> int'(fill) <= int'($past(fill)));  // R8

    AST_GROWTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid && raw_ready |=> int'(fill) <= int'($past(fill)) + NELEM);  // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |-> int'(fill) <= DEPTH);  // R8

endmodule

bind tree_debias tree_debias_chk #(
    .NELEM (N_ELEM),
    .FAW   (FIFO_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_valid (raw_valid),
    .raw_ready (raw_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_bit   (out_bit),
    .fill      (fifo_fill)
);

// File: tb/tree_debias_bench.sv
module tree_debias_bench;

    localparam int          NI    = 3;
    localparam logic [63:0] SH_A  = 64'b11100100;        // 4 elements, incomplete
    localparam int          LEN_A = 8;
    localparam logic [63:0] SH_B  = 64'b10;              // single element
    localparam int          LEN_B = 2;
    localparam logic [63:0] SH_C  = 64'b11100100110010;  // complete, 7 elements
    localparam int          LEN_C = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [NI-1:0] rv = '0;
    logic [NI-1:0] rb = '0;
    logic [NI-1:0] ordy = '0;
    logic [NI-1:0] rr;
    logic [NI-1:0] ob;
    logic [NI-1:0] ov;

    tree_debias #(.SHAPE_LEN(LEN_A), .SHAPE(SH_A), .FIFO_AW(4)) u_tree_debias (
        .clk(clk), .rst_n(rst_n), .raw_bit(rb[0]), .raw_valid(rv[0]), .raw_ready(rr[0]),
        .out_bit(ob[0]), .out_valid(ov[0]), .out_ready(ordy[0]));
    tree_debias #(.SHAPE_LEN(LEN_B), .SHAPE(SH_B), .FIFO_AW(4)) u_tree_debias_vn (
        .clk(clk), .rst_n(rst_n), .raw_bit(rb[1]), .raw_valid(rv[1]), .raw_ready(rr[1]),
        .out_bit(ob[1]), .out_valid(ov[1]), .out_ready(ordy[1]));
    tree_debias #(.SHAPE_LEN(LEN_C), .SHAPE(SH_C), .FIFO_AW(4)) u_tree_debias_full (
        .clk(clk), .rst_n(rst_n), .raw_bit(rb[2]), .raw_valid(rv[2]), .raw_ready(rr[2]),
        .out_bit(ob[2]), .out_valid(ov[2]), .out_ready(ordy[2]));

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;

    // reference tree models
    int lc [NI][16];
    int rc [NI][16];
    int nn [NI];
    bit have [NI][16];
    bit fst  [NI][16];
    bit expq [NI][$];
    bit gotq [NI][$];
    bit vnq [$];
    bit vn_have;
    bit vn_first;
    bit hold_pend [NI];
    bit hold_bit  [NI];
    int hold_err  [NI];
    bit saw_block;
    int acc_cnt;
    bit s_ov, s_ob, s_rr;

    task automatic check(bit ok, string req, string what, int act, int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic void build(int s, logic [63:0] v, int len);
        int stk [16];
        int sp = 0;
        int ap = -1;
        bit aleft = 1'b0;
        int cnt = 0;
        for (int k = 0; k < 16; k++) begin
            lc[s][k] = -1;
            rc[s][k] = -1;
        end
        for (int p = 0; p < len; p++) begin
            if (v[6'(len - 1 - p)]) begin
                if (ap >= 0) begin
                    if (aleft) lc[s][ap] = cnt;
                    else       rc[s][ap] = cnt;
                end
                stk[sp] = cnt;
                sp++;
                ap = cnt;
                aleft = 1'b1;
                cnt++;
            end else begin
                sp--;
                ap = stk[sp];
                aleft = 1'b0;
            end
        end
        nn[s] = cnt;
    endfunction

    task automatic model_push(int s, bit b);
        bit iv [16];
        bit ib [16];
        for (int k = 0; k < 16; k++) begin
            iv[k] = 1'b0;
            ib[k] = 1'b0;
        end
        iv[0] = 1'b1;
        ib[0] = b;
        for (int k = 0; k < nn[s]; k++) begin
            if (iv[k]) begin
                if (!have[s][k]) begin
                    have[s][k] = 1'b1;
                    fst[s][k]  = ib[k];
                end else begin
                    bit a;
                    a = fst[s][k];
                    have[s][k] = 1'b0;
                    if (a != ib[k]) expq[s].push_back(ib[k]);
                    if (lc[s][k] >= 0) begin
                        iv[lc[s][k]] = 1'b1;
                        ib[lc[s][k]] = a ^ ib[k];
                    end
                    if (a == ib[k] && rc[s][k] >= 0) begin
                        iv[rc[s][k]] = 1'b1;
                        ib[rc[s][k]] = a;
                    end
                end
            end
        end
        if (s == 1) begin
            if (!vn_have) begin
                vn_have  = 1'b1;
                vn_first = b;
            end else begin
                vn_have = 1'b0;
                if (vn_first != b) vnq.push_back(b);
            end
        end
    endtask

    task automatic step(int s, bit v, bit b, bit r);
        @(negedge clk);
        rv[s]   = v;
        rb[s]   = b;
        ordy[s] = r;
        #1;
        s_ov = ov[s];
        s_ob = ob[s];
        s_rr = rr[s];
        if (hold_pend[s] && (!s_ov || s_ob != hold_bit[s])) hold_err[s]++;
        hold_pend[s] = s_ov && !r;
        hold_bit[s]  = s_ob;
        if (!s_rr) saw_block = 1'b1;
        if (v && s_rr) begin
            model_push(s, b);
            acc_cnt++;
        end
        if (s_ov && r) gotq[s].push_back(s_ob);
    endtask

    task automatic drain(int s, int n);
        for (int i = 0; i < n; i++) step(s, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rv = '0;
        rb = '0;
        ordy = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int s = 0; s < NI; s++) begin
            for (int k = 0; k < 16; k++) have[s][k] = 1'b0;
            expq[s].delete();
            gotq[s].delete();
            hold_pend[s] = 1'b0;
            hold_err[s]  = 0;
        end
        vnq.delete();
        vn_have   = 1'b0;
        saw_block = 1'b0;
        acc_cnt   = 0;
    endtask

    task automatic cmp_seq(int s, string req, bit classic);
        bit e [$];
        int mism = 0;
        int n;
        if (classic) e = vnq;
        else         e = expq[s];
        check(gotq[s].size() == e.size(), req, "output length", gotq[s].size(), e.size());
        n = (gotq[s].size() < e.size()) ? gotq[s].size() : e.size();
        for (int i = 0; i < n; i++) begin
            if (gotq[s][i] != e[i]) mism++;
        end
        check(mism == 0, req, "mismatching output bits", mism, 0);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        #1;
        for (int s = 0; s < NI; s++) begin
            check(ov[s] == 1'b0, "R10", "out_valid after reset", int'(ov[s]), 0);
            check(rr[s] == 1'b1, "R10", "raw_ready after reset", int'(rr[s]), 1);
        end
    endtask

    task automatic t_latency();
        do_reset();
        step(0, 1'b1, 1'b0, 1'b0);
        step(0, 1'b1, 1'b1, 1'b0);
        check(s_ov == 1'b0, "R7", "out_valid after first bit of pair", int'(s_ov), 0);
        step(0, 1'b0, 1'b0, 1'b0);
        check(s_ov == 1'b1, "R7", "out_valid one cycle after pair", int'(s_ov), 1);
        check(s_ob == 1'b1, "R3", "pair 01 gives 1", int'(s_ob), 1);
        step(0, 1'b1, 1'b1, 1'b0);
        step(0, 1'b1, 1'b0, 1'b0);
        drain(0, 6);
        cmp_seq(0, "R3", 1'b0);
    endtask

    task automatic t_classic();
        do_reset();
        for (int i = 0; i < 300; i++)
            step(1, ($urandom % 5) != 0, ($urandom % 10) < 3, 1'b1);
        drain(1, 20);
        cmp_seq(1, "R11", 1'b1);
        check(vnq.size() > 10, "R2", "classic stream non-trivial", vnq.size(), 11);
    endtask

    task automatic t_random(int s, string req);
        do_reset();
        for (int i = 0; i < 400; i++)
            step(s, ($urandom % 4) != 0, ($urandom % 8) < 3, ($urandom % 3) != 0);
        drain(s, 40);
        cmp_seq(s, req, 1'b0);
        check(hold_err[s] == 0, "R9", "output changed while stalled", hold_err[s], 0);
    endtask

    task automatic t_backpressure();
        do_reset();
        for (int i = 0; i < 60; i++) step(0, 1'b1, i[0], 1'b0);
        check(saw_block == 1'b1, "R8", "raw_ready dropped when buffer near full", int'(saw_block), 1);
        check(acc_cnt < 60, "R8", "raw bits accepted while blocked", acc_cnt, 26);
        drain(0, 30);
        cmp_seq(0, "R8", 1'b0);
        check(hold_err[0] == 0, "R9", "output changed while stalled", hold_err[0], 0);
    endtask

    task automatic t_midreset();
        do_reset();
        step(0, 1'b1, 1'b1, 1'b0);
        step(0, 1'b0, 1'b0, 1'b0);
        do_reset();
        @(negedge clk);
        #1;
        check(ov[0] == 1'b0, "R10", "out_valid after mid-stream reset", int'(ov[0]), 0);
        step(0, 1'b1, 1'b1, 1'b0);
        step(0, 1'b1, 1'b0, 1'b0);
        step(0, 1'b0, 1'b0, 1'b0);
        check(s_ov == 1'b1, "R2", "pairing restarts after reset", int'(s_ov), 1);
        check(s_ob == 1'b0, "R3", "pair 10 gives 0", int'(s_ob), 0);
        drain(0, 4);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        build(0, SH_A, LEN_A);
        build(1, SH_B, LEN_B);
        build(2, SH_C, LEN_C);
        t_reset();
        t_latency();
        t_classic();
        t_random(0, "R6 R1 R4 R5");  // incomplete 4-element shape
        t_random(2, "R6 R1 R4 R5");  // complete 7-element shape
        t_backpressure();
        t_midreset();
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule